// File: doc/BRIEF.md
# 8x8 Forward Two-Dimensional DCT with DC-Row Offset Correction

This block computes the two-dimensional forward discrete cosine transform Z = T·X·Tᵀ of one 8x8 block of unsigned samples. Here T is the 8x8 DCT basis matrix, scaled by 2^14. Samples enter one per enabled clock in row-major order and keep their unsigned range of 0 to 2^SAMPLE_W-1. Centring around zero is not done per sample. The first pass of the transform starts row 0 of each column of T·X from its product minus a single constant. That gives eight corrections per block instead of sixty-four subtractions. Rows 1 to 7 of the scaled matrix each sum to zero, so the mid-scale offset cancels there with no correction.

The first pass (T·X) builds up as the samples arrive. It uses eight multipliers, one per basis row, and writes into a 64-entry accumulator bank. When the block is complete, the intermediate matrix is rounded by 14 bits and copied to a holding buffer. The second pass (·Tᵀ) then produces one coefficient per clock from an eight-term dot product and rounds it by 14 bits the same way. The result is 64 signed coefficients, which leave in column-major order. A valid strobe marks each coefficient, and a done pulse marks the last one. With PIPE2 = 1, one register stage is placed between the dot product and the output rounding.

The source must send each block as 64 consecutive enabled cycles. It then holds enable high for at least 33 more cycles without new data. After that, enable drops for one cycle before the next block.

Top module: `dct8_fwd_2d`

## Requirements
- R1: After reset, and while no complete block has been taken, coef_valid and block_done stay low.
- R2: A block is the first 64 enabled cycles after reset or after a cycle with en low. Sample n of the block is matrix element row n/8, column n%8.
- R3: Enabled cycles after the 64th sample, up to the next cycle with en low, take no data. Their sample values do not change the result.
- R4: If en falls before 64 samples are taken, the partial block is discarded. It produces no output, and the next enabled cycle starts a new block.
- R5: The output equals the transform of the samples minus 2^(SAMPLE_W-1). With SAMPLE_W = 8: a uniform block of 128 gives all zeros; a uniform block of 255 gives DC 1015 and zero elsewhere; a uniform block of 0 gives DC -1024 and zero elsewhere.
- R6: Both passes use basis constants round(8192·cos((2i+1)uπ/16)) for u > 0 and 5793 for u = 0. Each pass result is rounded as floor((s + 2^13) / 2^14). Every coefficient is within ±1 of an integer model built that way.
- R7: Coefficient k of a block is Z[k%8][k/8] (column-major: row index u in bits 2:0, column index v in bits 5:3 of k). It is a COEF_W-bit two's-complement value, and its magnitude never exceeds 2^(SAMPLE_W+2).
- R8: The first coefficient is valid on the second clock edge after the edge that takes sample 63, or the third edge when PIPE2 = 1. coef_valid then stays high for exactly 64 consecutive cycles.
- R9: block_done is high for exactly one cycle, together with the 64th coefficient, and at no other time.
- R10: Blocks sent at the minimum spacing (64 data cycles, 33 idle enabled cycles, one cycle with en low) each give correct and independent results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enable; frames blocks as described in R2 to R4 |
| sample_in | input | SAMPLE_W | Unsigned sample, taken on enabled data cycles |
| coef_out | output | COEF_W | Signed coefficient, column-major order |
| coef_valid | output | 1 | coef_out holds a coefficient this cycle |
| block_done | output | 1 | Marks the 64th coefficient of a block |

## Verification
The only result with a fixed delay is the coefficient run. Its first beat is due 2 + PIPE2 edges after the edge that takes sample 63, and its last beat comes 63 cycles after that. The bench records the cycle on which it drives sample 63 and the cycle of the first and last valid beats it sees, and compares them against that count. A bound checker checks the same delay against a sample counter it keeps itself from en. Coefficients are compared only after the whole run has been collected, because at the minimum block spacing the next block is already arriving while the previous one is being emitted.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
   localparam int N       = 8;
   localparam int NN      = N * N;
   localparam int CONST_W = 16;
   localparam int FRAC    = 14;

   typedef logic [2:0] pos_t;
   typedef logic [5:0] blk_idx_t;

   // Basis entry T[u][i] scaled by 2^14; rows 1..7 are built from one
   // folded magnitude table so their entries sum to exactly zero.
   function automatic logic signed [CONST_W-1:0] dct_coef(input int u, input int i);
      int   m;
      int   mag;
      logic neg;
      if (u == 0) return CONST_W'(5793);
      m   = ((2 * i + 1) * u) % 32;
      if (m > 16) m = 32 - m;
      neg = 1'b0;
      if (m > 8) begin
         m   = 16 - m;
         neg = 1'b1;
      end
      case (m)
         0:       mag = 8192;
         1:       mag = 8035;
         2:       mag = 7568;
         3:       mag = 6811;
         4:       mag = 5793;
         5:       mag = 4551;
         6:       mag = 3135;
         7:       mag = 1598;
         default: mag = 0;
      endcase
      return neg ? CONST_W'(-mag) : CONST_W'(mag);
   endfunction
endpackage

// File: rtl/dct8_in_ctrl.sv
module dct8_in_ctrl
   import dct8_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic take,
   output pos_t row,
   output pos_t col,
   output logic blk_full
);
   localparam logic [6:0] LAST = 7'(NN - 1);
   localparam logic [6:0] FULL = 7'(NN);

   logic [6:0] cnt;

   assign take = en && (cnt < FULL);
   assign row  = cnt[5:3];
   assign col  = cnt[2:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         blk_full <= 1'b0;
      end else begin
         blk_full <= take && (cnt == LAST);
         if (!en)
            cnt <= '0;
         else if (take)
            cnt <= cnt + 7'd1;
      end
   end
endmodule

// File: rtl/dct8_col_acc.sv
module dct8_col_acc
   import dct8_pkg::*;
#(
   parameter int SAMPLE_W = 8,
   parameter int ACC1_W   = 27,
   parameter int MID_W    = 11
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      take,
   input  pos_t                      row,
   input  pos_t                      col,
   input  logic [SAMPLE_W-1:0]       sample,
   output logic signed [MID_W-1:0]   y_out [N][N]
);
   // Mid-scale offset times the DC basis entry, summed over one column.
   localparam signed [ACC1_W-1:0] DC_BIAS =
      ACC1_W'(N * (1 << (SAMPLE_W - 1)) * int'(dct_coef(0, 0)));
   localparam signed [ACC1_W-1:0] HALF = ACC1_W'(1 << (FRAC - 1));

   logic signed [ACC1_W-1:0] x_ext;
   assign x_ext = ACC1_W'($signed({1'b0, sample}));

   for (genvar gu = 0; gu < N; gu++) begin : g_row
      localparam signed [ACC1_W-1:0] ROW_BIAS = (gu == 0) ? DC_BIAS : '0;

      logic signed [CONST_W-1:0] t_c;
      logic signed [ACC1_W-1:0]  prod;
      logic signed [ACC1_W-1:0]  acc [N];

      always_comb t_c = dct_coef(gu, int'(row));
      assign prod = ACC1_W'(t_c) * x_ext;

      // First row of each column seeds the sum; only basis row 0 carries the bias.
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int j = 0; j < N; j++) acc[j] <= '0;
         end else if (take) begin
            if (row == '0)
               acc[col] <= prod - ROW_BIAS;
            else
               acc[col] <= acc[col] + prod;
         end
      end

      for (genvar gj = 0; gj < N; gj++) begin : g_col
         logic signed [ACC1_W-1:0] rnd;
         assign rnd             = acc[gj] + HALF;
         assign y_out[gu][gj]   = MID_W'(rnd >>> FRAC);
      end
   end
endmodule

// File: rtl/dct8_row_eng.sv
module dct8_row_eng
   import dct8_pkg::*;
#(
   parameter int MID_W  = 11,
   parameter int ACC2_W = 31,
   parameter int COEF_W = 12,
   parameter int PIPE2  = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic signed [MID_W-1:0]  y_in [N][N],
   output logic [COEF_W-1:0]        coef,
   output logic                     coef_valid,
   output logic                     block_done
);
   localparam signed [ACC2_W-1:0] HALF = ACC2_W'(1 << (FRAC - 1));
   localparam blk_idx_t LAST_IDX = blk_idx_t'(NN - 1);

   logic signed [MID_W-1:0]  ybuf [N][N];
   blk_idx_t                 idx;
   logic                     busy;
   pos_t                     u_sel;
   pos_t                     v_sel;
   logic signed [ACC2_W-1:0] term [N];
   logic signed [ACC2_W-1:0] sum;
   logic                     last_beat;

   assign u_sel     = idx[2:0];
   assign v_sel     = idx[5:3];
   assign last_beat = busy && (idx == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
         for (int a = 0; a < N; a++)
            for (int b = 0; b < N; b++) ybuf[a][b] <= '0;
      end else if (load) begin
         busy <= 1'b1;
         idx  <= '0;
         ybuf <= y_in;
      end else if (busy) begin
         idx  <= idx + 6'd1;
         busy <= !last_beat;
      end
   end

   for (genvar gk = 0; gk < N; gk++) begin : g_tap
      logic signed [CONST_W-1:0] t_c;
      always_comb t_c = dct_coef(int'(v_sel), gk);
      assign term[gk] = ACC2_W'(ybuf[u_sel][gk]) * ACC2_W'(t_c);
   end

   always_comb begin
      sum = '0;
      for (int k = 0; k < N; k++) sum = sum + term[k];
   end

   if (PIPE2 == 0) begin : g_direct
      logic signed [ACC2_W-1:0] rnd;
      assign rnd = sum + HALF;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            coef       <= '0;
            coef_valid <= 1'b0;
            block_done <= 1'b0;
         end else begin
            coef       <= COEF_W'(rnd >>> FRAC);
            coef_valid <= busy;
            block_done <= last_beat;
         end
      end
   end else begin : g_staged
      logic signed [ACC2_W-1:0] sum_q;
      logic signed [ACC2_W-1:0] rnd;
      logic                     st_v;
      logic                     st_last;
      assign rnd = sum_q + HALF;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sum_q      <= '0;
            st_v       <= 1'b0;
            st_last    <= 1'b0;
            coef       <= '0;
            coef_valid <= 1'b0;
            block_done <= 1'b0;
         end else begin
            sum_q      <= sum;
            st_v       <= busy;
            st_last    <= last_beat;
            coef       <= COEF_W'(rnd >>> FRAC);
            coef_valid <= st_v;
            block_done <= st_last;
         end
      end
   end
endmodule

// File: rtl/dct8_fwd_2d.sv
module dct8_fwd_2d
   import dct8_pkg::*;
#(
   parameter int SAMPLE_W = 8,
   parameter int COEF_W   = 12,
   parameter int PIPE2    = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [SAMPLE_W-1:0] sample_in,
   output logic [COEF_W-1:0]   coef_out,
   output logic                coef_valid,
   output logic                block_done
);
   localparam int ACC1_W = SAMPLE_W + FRAC + 5;
   localparam int MID_W  = SAMPLE_W + 3;
   localparam int ACC2_W = MID_W + CONST_W + 4;

   if (SAMPLE_W < 4 || SAMPLE_W > 12) begin : g_bad_sample_w
      $error("dct8_fwd_2d: SAMPLE_W must be 4..12");
   end
   if (COEF_W < SAMPLE_W + 3 || COEF_W > 32) begin : g_bad_coef_w
      $error("dct8_fwd_2d: COEF_W must be SAMPLE_W+3..32");
   end
   if (PIPE2 != 0 && PIPE2 != 1) begin : g_bad_pipe
      $error("dct8_fwd_2d: PIPE2 must be 0 or 1");
   end

   logic                    take;
   pos_t                    row;
   pos_t                    col;
   logic                    blk_full;
   logic signed [MID_W-1:0] y_mid [N][N];

   dct8_in_ctrl u_in (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .take     (take),
      .row      (row),
      .col      (col),
      .blk_full (blk_full)
   );

   dct8_col_acc #(
      .SAMPLE_W (SAMPLE_W),
      .ACC1_W   (ACC1_W),
      .MID_W    (MID_W)
   ) u_pass1 (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take),
      .row    (row),
      .col    (col),
      .sample (sample_in),
      .y_out  (y_mid)
   );

   dct8_row_eng #(
      .MID_W  (MID_W),
      .ACC2_W (ACC2_W),
      .COEF_W (COEF_W),
      .PIPE2  (PIPE2)
   ) u_pass2 (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (blk_full),
      .y_in       (y_mid),
      .coef       (coef_out),
      .coef_valid (coef_valid),
      .block_done (block_done)
   );
endmodule

// File: rtl/dct8_fwd_2d_chk.sv
module dct8_fwd_2d_chk #(
   parameter int SAMPLE_W = 8,
   parameter int COEF_W   = 12,
   parameter int PIPE2    = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [COEF_W-1:0] coef_out,
   input logic              coef_valid,
   input logic              block_done
);
   localparam int LIM = 1 << (SAMPLE_W + 2);

   logic [6:0] seen;
   logic [5:0] vcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen <= '0;
         vcnt <= '0;
      end else begin
         if (!en)               seen <= '0;
         else if (seen < 7'd64) seen <= seen + 7'd1;
         if (coef_valid)        vcnt <= block_done ? 6'd0 : vcnt + 6'd1;
      end
   end

   // R1: nothing leaves the block in the first cycle out of reset
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!coef_valid && !block_done));

   // R8: first coefficient arrives a fixed number of edges after sample 63
   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && seen == 7'd63) |=> ##(2 + PIPE2) coef_valid);

   // R8: the coefficient run has no holes
   p_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (coef_valid && !block_done) |=> coef_valid);

   // R9: done only with the 64th valid beat
   p_done_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
      block_done |-> (coef_valid && vcnt == 6'd63));

   // R9: done is a single pulse and the run ends with it
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      block_done |=> (!block_done && !coef_valid));

   // R7: coefficient magnitude bound
   p_coef_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      coef_valid |-> ($signed(coef_out) <= LIM && $signed(coef_out) >= -LIM));
endmodule

bind dct8_fwd_2d dct8_fwd_2d_chk #(
   .SAMPLE_W (SAMPLE_W),
   .COEF_W   (COEF_W),
   .PIPE2    (PIPE2)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en         (en),
   .coef_out   (coef_out),
   .coef_valid (coef_valid),
   .block_done (block_done)
);

// File: tb/dct8_fwd_2d_tb_top.sv
module dct8_fwd_2d_tb_top;
   localparam int  PIPE  = 0;
   localparam int  MAXB  = 16;
   localparam real PI    = 3.14159265358979;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [7:0]  sample_in = '0;
   logic [11:0] coef_out;
   logic        coef_valid;
   logic        block_done;

   always #10 clk = ~clk;   // 50 MHz

   dct8_fwd_2d #(.SAMPLE_W(8), .COEF_W(12), .PIPE2(PIPE)) dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .sample_in(sample_in),
      .coef_out(coef_out), .coef_valid(coef_valid), .block_done(block_done)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   int    cyc = 0;
   bit    reported = 0;
   int    px   [MAXB][64];
   int    refz [MAXB][64];
   int    cap  [MAXB][64];
   int    expf [MAXB];
   int    capf [MAXB];
   int    capl [MAXB];
   int    donei[MAXB];
   string tag  [MAXB];
   int    nsent = 0;
   int    nout = 0;
   int    oidx = 0;
   int    tb_t [8][8];

   task automatic chk(input bit ok, input string req, input int act, input int exp_v);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", nout, nsent);
         report();
      end
   end

   // Output collector, sampling away from the active edge
   always @(negedge clk) begin
      if (rst_n && coef_valid && nout < MAXB) begin
         if (oidx < 64) cap[nout][oidx] = $signed(coef_out);
         if (oidx == 0) capf[nout] = cyc;
         capl[nout] = cyc;
         if (block_done) begin
            donei[nout] = oidx;
            nout++;
            oidx = 0;
         end else begin
            oidx++;
         end
      end
   end

   function automatic int tref(input int u, input int i);
      real r;
      if (u == 0) r = 16384.0 / $sqrt(8.0);
      else        r = 8192.0 * $cos(PI * real'((2 * i + 1) * u) / 16.0);
      return $rtoi(r + ((r >= 0.0) ? 0.5 : -0.5));
   endfunction

   function automatic int rnd14(input int a);
      return (a + 8192) >>> 14;
   endfunction

   // Integer model on centred samples; result stored column-major
   task automatic build_ref(input int b);
      int y [8][8];
      for (int u = 0; u < 8; u++)
         for (int j = 0; j < 8; j++) begin
            int s = 0;
            for (int i = 0; i < 8; i++) s += tb_t[u][i] * (px[b][i*8+j] - 128);
            y[u][j] = rnd14(s);
         end
      for (int u = 0; u < 8; u++)
         for (int v = 0; v < 8; v++) begin
            int s = 0;
            for (int k = 0; k < 8; k++) s += y[u][k] * tb_t[v][k];
            refz[b][v*8+u] = rnd14(s);
         end
   endtask

   task automatic send_block(input int b, input int gap);
      build_ref(b);
      for (int n = 0; n < 64; n++) begin
         @(negedge clk);
         en = 1'b1;
         sample_in = 8'(px[b][n]);
         if (n == 63) expf[b] = cyc + 3 + PIPE;
      end
      for (int g = 0; g < gap; g++) begin
         @(negedge clk);
         sample_in = 8'($urandom);   // junk while idle (R3)
      end
      @(negedge clk);
      en = 1'b0;
      sample_in = 8'($urandom);
      nsent++;
   endtask

   task automatic send_partial(input int cnt);
      for (int n = 0; n < cnt; n++) begin
         @(negedge clk);
         en = 1'b1;
         sample_in = 8'($urandom);
      end
      @(negedge clk);
      en = 1'b0;
   endtask

   initial begin
      void'($urandom(32'h1d5));
      for (int u = 0; u < 8; u++)
         for (int i = 0; i < 8; i++) tb_t[u][i] = tref(u, i);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         chk(!coef_valid, "R1 valid after reset", int'(coef_valid), 0);
         chk(!block_done, "R1 done after reset", int'(block_done), 0);
      end

      // b0..b2 uniform, b3 horizontal ramp
      for (int n = 0; n < 64; n++) begin
         px[0][n] = 128; px[1][n] = 255; px[2][n] = 0; px[3][n] = (n % 8) * 32;
      end
      tag[0] = "R5"; tag[1] = "R5"; tag[2] = "R5"; tag[3] = "R7";
      send_block(0, 40);
      send_block(1, 33);
      send_block(2, 33);
      send_block(3, 35);

      // partial block dropped, then an impulse block (R4, R2)
      send_partial(20);
      for (int n = 0; n < 64; n++) px[4][n] = 128;
      px[4][2*8+5] = 255;
      tag[4] = "R4";
      send_block(4, 33);

      // random blocks at minimum and relaxed spacing
      for (int b = 5; b < 12; b++) begin
         for (int n = 0; n < 64; n++)
            px[b][n] = (b == 11) ? (($urandom % 2) != 0 ? 255 : 0) : int'($urandom % 256);
         tag[b] = (b == 5) ? "R3" : ((b % 2) != 0 ? "R10" : "R6");
         send_block(b, (b % 2) != 0 ? 33 : 50);
      end

      wait (nout == nsent);
      repeat (10) @(negedge clk);

      chk(nout == nsent, "R4 block count", nout, nsent);
      chk(!coef_valid, "R9 quiet after last block", int'(coef_valid), 0);
      for (int b = 0; b < nsent; b++) begin
         chk(capf[b] == expf[b], "R8 first-beat cycle", capf[b], expf[b]);
         chk(capl[b] - capf[b] == 63, "R8 run length", capl[b] - capf[b], 63);
         chk(donei[b] == 63, "R9 done position", donei[b], 63);
         for (int o = 0; o < 64; o++) begin
            int d = cap[b][o] - refz[b][o];
            chk(d <= 1 && d >= -1, {tag[b], " R6 coef vs model"}, cap[b][o], refz[b][o]);
         end
      end
      for (int o = 0; o < 64; o++)
         chk(cap[0][o] == 0, "R5 mid-scale block zero", cap[0][o], 0);
      chk(cap[1][0] == 1015, "R5 full-scale DC", cap[1][0], 1015);
      chk(cap[2][0] == -1024, "R5 zero block DC", cap[2][0], -1024);
      chk(cap[1][9] == 0, "R5 full-scale AC", cap[1][9], 0);
      chk(cap[3][1] == 0, "R7 ramp Z[1][0] at index 1", cap[3][1], 0);
      chk(cap[3][8] < -100, "R7 ramp Z[0][1] at index 8", cap[3][8], refz[3][8]);
      chk(cap[4][2*8+5] == refz[4][2*8+5], "R2 impulse coefficient", cap[4][21], refz[4][21]);
      report();
   end
endmodule